// File: doc/BRIEF.md
# Long multiply-accumulate execution unit

This execution unit forms the full 64-bit product of two 32-bit operands. A 2-bit operation code picks one of four functions: unsigned multiply, unsigned multiply-accumulate, signed multiply, and signed multiply-accumulate. For the accumulate functions, a 64-bit addend arrives as a high word and a low word. The 64-bit result leaves on the same kind of split high/low pair, so a register file can write it straight back to two destination registers.

An operation begins when `start` is sampled high while the unit is idle. The product is registered on that edge. The accumulate sum is registered on the next edge, when `done` pulses. The unit also compares the two destination register indices and raises `illegal` together with `done` when they are the same. The condition-flag bus passes through unchanged, so the operation never alters the flags.

Top module: `lmac_unit`

## Requirements
- R1: With `op` = 2'b00 (unsigned multiply), the result is the unsigned 64-bit product of `opa` and `opb`. The low 32 bits appear on `res_lo` and the high 32 bits on `res_hi`. The accumulator inputs have no effect.
- R2: With `op` = 2'b01 (unsigned accumulate), the result is the unsigned product plus the unsigned 64-bit value {`acc_hi`,`acc_lo`}.
- R3: With `op` = 2'b10 (signed multiply), both operands are two's complement, and the result is their signed 64-bit product. The accumulator inputs have no effect.
- R4: With `op` = 2'b11 (signed accumulate), the result is the signed product plus the signed 64-bit value {`acc_hi`,`acc_lo`}. In the code, `op[1]` selects signed and `op[0]` selects accumulate.
- R5: The accumulate sum wraps modulo 2^64. A carry out of bit 63 is discarded, and no overflow indication exists.
- R6: A start accepted on a rising edge makes `done` high for exactly one cycle after the second rising edge from it, with the result on `res_hi`/`res_lo`. The result holds until the next result is produced.
- R7: `busy` is high for the one cycle after an accepted start. A `start` sampled while `busy` is high is ignored and produces no result.
- R8: `illegal` is high together with `done` when the operation's `idx_hi` equals its `idx_lo`. Otherwise it is low.
- R9: `flags_out` equals `flags_in` at all times.
- R10: Synchronous active-high reset clears `res_hi`, `res_lo`, `done`, `busy` and `illegal` to zero, and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 2 | Function code: bit 1 signed, bit 0 accumulate |
| opa | input | 32 | First multiplicand |
| opb | input | 32 | Second multiplicand |
| acc_hi | input | 32 | Upper word of the addend |
| acc_lo | input | 32 | Lower word of the addend |
| idx_hi | input | 4 | Destination register index for the upper word |
| idx_lo | input | 4 | Destination register index for the lower word |
| flags_in | input | 4 | Incoming condition flags |
| res_hi | output | 32 | Upper result word |
| res_lo | output | 32 | Lower result word |
| done | output | 1 | One-cycle result-valid pulse |
| busy | output | 1 | Operation in flight; start is ignored |
| illegal | output | 1 | Destination indices were equal (valid with done) |
| flags_out | output | 4 | Outgoing condition flags, equal to flags_in |

## Verification
The bench drives inputs on falling edges and counts rising edges from the edge that accepts a start:
- `busy` is expected high at the falling edge after the first rising edge.
- `done`, `res_hi`/`res_lo` and `illegal` are expected at the falling edge after the second rising edge.
- At the falling edge after that, `done` must be low again while the result is unchanged.

`flags_out` has no register in its path, so it is compared a moment after each change of `flags_in`. The ignored-start case holds `start` high across the busy cycle with different operands. It then confirms that only the first operation's result appears and that no second `done` follows.

// File: rtl/lmac_pkg.sv
package lmac_pkg;
  typedef enum logic [1:0] {
    OP_UMUL = 2'b00,
    OP_UMAC = 2'b01,
    OP_SMUL = 2'b10,
    OP_SMAC = 2'b11
  } lmac_op_e;

  function automatic logic op_signed(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic op_accum(input logic [1:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/lmac_mul_stage.sv
module lmac_mul_stage #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [1:0]      op,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [DW-1:0]   acc_hi,
  input  logic [DW-1:0]   acc_lo,
  input  logic            pair_bad,
  output logic            vld,
  output logic [2*DW-1:0] prod_q,
  output logic [2*DW-1:0] addend_q,
  output logic            bad_q
);
  import lmac_pkg::*;
  localparam int PW = 2 * DW;

  logic               sgn;
  logic signed [DW:0] ext_a, ext_b;
  logic signed [PW+1:0] full;

  always_comb begin
    sgn   = op_signed(op);
    ext_a = {sgn & opa[DW-1], opa};
    ext_b = {sgn & opb[DW-1], opb};
    full  = ext_a * ext_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= 1'b0;
      prod_q   <= '0;
      addend_q <= '0;
      bad_q    <= 1'b0;
    end else begin
      vld <= fire;
      if (fire) begin
        prod_q   <= full[PW-1:0];
        addend_q <= op_accum(op) ? {acc_hi, acc_lo} : '0;
        bad_q    <= pair_bad;
      end
    end
  end

  // R7
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);
endmodule

// File: rtl/lmac_acc_stage.sv
module lmac_acc_stage #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic [2*DW-1:0] prod,
  input  logic [2*DW-1:0] addend,
  input  logic            bad,
  output logic            done,
  output logic [DW-1:0]   res_hi,
  output logic [DW-1:0]   res_lo,
  output logic            illegal
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] sum;

  always_comb sum = prod + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
      illegal <= 1'b0;
    end else begin
      done <= vld;
      if (vld) begin
        res_hi  <= sum[PW-1:DW];
        res_lo  <= sum[DW-1:0];
        illegal <= bad;
      end else begin
        illegal <= 1'b0;
      end
    end
  end

  // R6
  done_follows_stage_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |=> ($stable(res_hi) && $stable(res_lo)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && !illegal && res_hi == '0 && res_lo == '0));
endmodule

// File: rtl/lmac_unit.sv
module lmac_unit #(
  parameter int DW     = 32,
  parameter int IDX_W  = 4,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DW-1:0]     opa,
  input  logic [DW-1:0]     opb,
  input  logic [DW-1:0]     acc_hi,
  input  logic [DW-1:0]     acc_lo,
  input  logic [IDX_W-1:0]  idx_hi,
  input  logic [IDX_W-1:0]  idx_lo,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DW-1:0]     res_hi,
  output logic [DW-1:0]     res_lo,
  output logic              done,
  output logic              busy,
  output logic              illegal,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int PW = 2 * DW;

  logic          fire, pair_bad, s1_vld, s1_bad;
  logic [PW-1:0] s1_prod, s1_addend;

  assign busy      = s1_vld;
  assign fire      = start & ~s1_vld;
  assign pair_bad  = (idx_hi == idx_lo);
  assign flags_out = flags_in;

  lmac_mul_stage #(.DW(DW)) u_mul (
    .clk(clk), .rst(rst), .fire(fire), .op(op),
    .opa(opa), .opb(opb), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .pair_bad(pair_bad), .vld(s1_vld), .prod_q(s1_prod),
    .addend_q(s1_addend), .bad_q(s1_bad)
  );

  lmac_acc_stage #(.DW(DW)) u_acc (
    .clk(clk), .rst(rst), .vld(s1_vld), .prod(s1_prod),
    .addend(s1_addend), .bad(s1_bad), .done(done),
    .res_hi(res_hi), .res_lo(res_lo), .illegal(illegal)
  );

  // R8
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && idx_hi == idx_lo) |=> ##1 (done && illegal));

  // R8
  legal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && idx_hi != idx_lo) |=> ##1 (done && !illegal));

  // R7
  ignored_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ##1 !done);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (busy && !done));
endmodule

// File: tb/sim_lmac_unit.sv
module sim_lmac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0, acc_hi = '0, acc_lo = '0;
  logic [3:0]  idx_hi = 4'd1, idx_lo = 4'd0, flags_in = 4'b0000;
  logic [31:0] res_hi, res_lo;
  logic        done, busy, illegal;
  logic [3:0]  flags_out;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lmac_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .idx_hi(idx_hi), .idx_lo(idx_lo),
    .flags_in(flags_in), .res_hi(res_hi), .res_lo(res_lo), .done(done),
    .busy(busy), .illegal(illegal), .flags_out(flags_out)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] acc;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'd1, 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0, 64'hFFFFFFFE_00000001},         // R1
    '{4'd1, 2'b00, 32'hFFFFFFFF, 32'h00000002, 64'h0, 64'h00000001_FFFFFFFE},         // R1
    '{4'd1, 2'b00, 32'h00000003, 32'h00000005, 64'h12345678_9ABCDEF0, 64'd15},        // R1 addend ignored
    '{4'd3, 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0, 64'h00000000_00000001},         // R3
    '{4'd3, 2'b10, 32'hFFFFFFFF, 32'h00000002, 64'hFFFF0000_0000FFFF, 64'hFFFFFFFF_FFFFFFFE}, // R3
    '{4'd3, 2'b10, 32'h80000000, 32'h7FFFFFFF, 64'h0, 64'hC0000000_80000000},         // R3
    '{4'd2, 2'b01, 32'h00000010, 32'h00000010, 64'h00000001_00000000, 64'h00000001_00000100}, // R2
    '{4'd5, 2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFE_00000000}, // R5
    '{4'd4, 2'b11, 32'hFFFFFFFF, 32'h00000001, 64'h0, 64'hFFFFFFFF_FFFFFFFF},         // R4
    '{4'd4, 2'b11, 32'h80000000, 32'h80000000, 64'hFFFFFFFF_FFFFFFFF, 64'h3FFFFFFF_FFFFFFFF}  // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operation and check it at the cycles it is due
  task automatic run_op(input string req, input logic [1:0] f, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] acc,
                        input logic [3:0] ih, input logic [3:0] il, input logic [63:0] exp);
    @(negedge clk);
    op = f; opa = a; opb = b; {acc_hi, acc_lo} = acc; idx_hi = ih; idx_lo = il;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " busy/done after accept (R7)"}, {62'd0, busy, done}, 64'b10);
    @(negedge clk);
    chk({req, " done due (R6)"}, {63'd0, done}, 64'd1);
    chk({req, " result"}, {res_hi, res_lo}, exp);
    chk({req, " illegal (R8)"}, {63'd0, illegal}, {63'd0, ih == il});
    @(negedge clk);
    chk({req, " done drops, result held (R6)"}, {done, res_hi[30:0], res_lo}, {1'b0, exp[62:0]});
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    flags_in = 4'b1010;
    repeat (3) @(negedge clk);
    // R9 during reset
    chk("R9 flags in reset", {60'd0, flags_out}, 64'hA);
    // R10 reset state
    chk("R10 reset state", {res_hi, res_lo}, 64'd0);
    chk("R10 reset ctrl", {61'd0, done, busy, illegal}, 64'd0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      string tag;
      tag = $sformatf("R%0d vec%0d", v.req, i);
      run_op(tag, v.op, v.a, v.b, v.acc, 4'd3, 4'd2, v.exp);
    end

    // R8 equal destination indices
    run_op("R8 equal idx", 2'b00, 32'd6, 32'd7, 64'd0, 4'd5, 4'd5, 64'd42);
    run_op("R8 distinct idx", 2'b00, 32'd6, 32'd7, 64'd0, 4'd5, 4'd4, 64'd42);

    // R7 start held through busy with different operands: second is ignored
    @(negedge clk);
    op = 2'b00; opa = 32'd9; opb = 32'd9; idx_hi = 4'd1; idx_lo = 4'd0; start = 1'b1;
    @(negedge clk);
    opa = 32'd2; opb = 32'd2;
    chk("R7 busy while in flight", {63'd0, busy}, 64'd1);
    @(negedge clk);
    start = 1'b0;
    chk("R7 first result", {res_hi, res_lo}, 64'd81);
    @(negedge clk);
    chk("R7 no second done", {62'd0, done, busy}, 64'd0);
    @(negedge clk);
    chk("R7 result unchanged", {res_hi, res_lo}, 64'd81);

    // R9 flags follow input
    flags_in = 4'b0101;
    #1 chk("R9 flags pass 0101", {60'd0, flags_out}, 64'h5);
    flags_in = 4'b1111;
    #1 chk("R9 flags pass 1111", {60'd0, flags_out}, 64'hF);

    // R10 reset mid-operation abandons it
    @(negedge clk);
    op = 2'b10; opa = 32'hFFFFFFFF; opb = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R10 mid-op clear", {res_hi, res_lo}, 64'd0);
    chk("R10 mid-op ctrl", {61'd0, done, busy, illegal}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 no late done", {63'd0, done}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule